// File: doc/BRIEF.md
# Transactional Store Undo Log Controller

This block manages data versions for a transactional memory scheme in which every transactional store updates memory in place at once. Before the new value is written, the block reads the value currently held at the target address and keeps the address and that old value in a local undo log. The new value then goes to its home location immediately, so other agents can see it before the transaction ends.

Ending a transaction successfully is cheap: a commit empties the log in one cycle and copies nothing. Ending it with an abort takes longer. The block walks the log from the newest entry to the oldest and writes each saved value back to its address. Because the oldest entry is replayed last, an address that was stored to several times ends up holding the value it had before the transaction began. While an abort replay runs, new stores wait. If the log fills up, the block refuses further stores until the transaction ends.

Top module: `undo_log_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `mem_rd_en`, `mem_wr_en`, `st_gnt`, `tx_done` and `log_ovf` are all 0, and the log is empty.
- R2: When an idle block samples `st_req` high and the log is neither full nor flagged, it drives `mem_rd_en` with `mem_rd_addr = st_addr` in the next cycle. It takes the old value from `mem_rd_data` one cycle after that read, in the same clock edge appends that value to the log, and raises `st_gnt` for exactly one cycle starting at that edge.
- R3: The write of the new value (`mem_wr_en`, `mem_wr_addr = st_addr`, `mem_wr_data = st_data`) is issued in the same cycle as `st_gnt`, before any commit.
- R4: A commit sampled while idle raises `tx_done` for one cycle in the next cycle. It issues no memory write, clears the log and clears `log_ovf`.
- R5: An abort sampled while idle with a non-empty log replays the entries newest-first, one write-back every two cycles, so every address logged during the transaction regains its value from before the transaction.
- R6: `tx_done` pulses for one cycle. On an abort it coincides with the last write-back, and on an abort with an empty log it appears in the cycle after the abort is sampled.
- R7: A store request sampled while the log holds `LOG_DEPTH` entries sets `log_ovf` and produces no read and no grant. `log_ovf` stays high, and further requests are refused, until the next commit or abort.
- R8: A store request raised during an abort replay gets no grant until the replay has finished and `tx_done` has pulsed. The store is then served normally.
- R9: `mem_rd_en` and `mem_wr_en` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| st_req | input | 1 | Transactional store request, held until grant or overflow |
| st_addr | input | ADDR_W | Store target address |
| st_data | input | DATA_W | Store new value |
| st_gnt | output | 1 | One-cycle grant, after the log entry is written |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | ADDR_W | Memory read address |
| mem_rd_data | input | DATA_W | Memory read data, valid one cycle after the strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | ADDR_W | Memory write address |
| mem_wr_data | output | DATA_W | Memory write data |
| tx_commit | input | 1 | One-cycle commit pulse |
| tx_abort | input | 1 | One-cycle abort pulse |
| tx_done | output | 1 | One-cycle completion pulse for commit or abort |
| log_ovf | output | 1 | Log full, stores refused |

## Verification
The assertions assume that the memory behind the port returns read data exactly one cycle after the strobe. They also assume that `tx_commit` and `tx_abort` arrive as single-cycle pulses, only while no store is between acceptance and grant, and never both at once. The bench drives its memory model with that one-cycle latency and issues commit and abort only after a store task has returned. It drops `st_req` in the cycle where it sees the grant or the overflow flag. The only request it overlaps with other activity is one raised on purpose during an abort replay.

// File: rtl/undo_pkg.sv
package undo_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD,
    S_CAP,
    S_WR,
    S_URD,
    S_UWR
  } ul_state_e;

endpackage

// File: rtl/undo_log_ram.sv
module undo_log_ram #(
  parameter int EW    = 24,
  parameter int DEPTH = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [PW-1:0] waddr,
  input  logic [EW-1:0] wdata,
  input  logic          re,
  input  logic [PW-1:0] raddr,
  output logic [EW-1:0] rdata
);

  logic [EW-1:0] store [DEPTH];

  // simple dual port, registered read: maps to block RAM
  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    if (re) rdata <= store[raddr];
  end

endmodule

// File: rtl/undo_log_cnt.sv
module undo_log_cnt #(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic          clr,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);

  always_ff @(posedge clk) begin
    if (rst || clr)  count <= '0;
    else if (push)   count <= count + CW'(1);
    else if (pop)    count <= count - CW'(1);
  end

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);

  // R7: occupancy never passes the configured depth
  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  // R5: append and replay never overlap
  a_r5_no_push_pop: assert property (@(posedge clk) disable iff (rst)
    !(push && pop));

endmodule

// File: rtl/undo_log_ctrl.sv
module undo_log_ctrl
  import undo_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int LOG_DEPTH = 8,
  localparam int EW       = ADDR_W + DATA_W,
  localparam int PW       = (LOG_DEPTH > 1) ? $clog2(LOG_DEPTH) : 1,
  localparam int CW       = $clog2(LOG_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              st_req,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  output logic              st_gnt,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  input  logic              tx_commit,
  input  logic              tx_abort,
  output logic              tx_done,
  output logic              log_ovf
);

  ul_state_e         state;
  logic [DATA_W-1:0] new_data_q;
  logic [CW-1:0]     count;
  logic [CW-1:0]     cnt_m1;
  logic              full, empty;
  logic              push, pop, clr;
  logic [EW-1:0]     ram_rdata;

  assign push   = (state == S_CAP);
  assign pop    = (state == S_URD);
  assign clr    = (state == S_IDLE) && tx_commit && !tx_abort;
  assign cnt_m1 = count - CW'(1);

  undo_log_cnt #(.DEPTH(LOG_DEPTH)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .push  (push),
    .pop   (pop),
    .clr   (clr),
    .count (count),
    .full  (full),
    .empty (empty)
  );

  undo_log_ram #(.EW(EW), .DEPTH(LOG_DEPTH)) u_ram (
    .clk   (clk),
    .we    (push),
    .waddr (count[PW-1:0]),
    .wdata ({mem_rd_addr, mem_rd_data}),
    .re    (pop),
    .raddr (cnt_m1[PW-1:0]),
    .rdata (ram_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      mem_rd_en   <= 1'b0;
      mem_rd_addr <= '0;
      mem_wr_en   <= 1'b0;
      mem_wr_addr <= '0;
      mem_wr_data <= '0;
      new_data_q  <= '0;
      st_gnt      <= 1'b0;
      tx_done     <= 1'b0;
      log_ovf     <= 1'b0;
    end else begin
      mem_rd_en <= 1'b0;
      mem_wr_en <= 1'b0;
      st_gnt    <= 1'b0;
      tx_done   <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (tx_abort) begin
            log_ovf <= 1'b0;
            if (empty) tx_done <= 1'b1;
            else       state   <= S_URD;
          end else if (tx_commit) begin
            log_ovf <= 1'b0;
            tx_done <= 1'b1;
          end else if (st_req && !log_ovf) begin
            if (full) begin
              log_ovf <= 1'b1;
            end else begin
              mem_rd_en   <= 1'b1;
              mem_rd_addr <= st_addr;
              new_data_q  <= st_data;
              state       <= S_RD;
            end
          end
        end
        S_RD:  state <= S_CAP;
        S_CAP: begin
          mem_wr_en   <= 1'b1;
          mem_wr_addr <= mem_rd_addr;
          mem_wr_data <= new_data_q;
          st_gnt      <= 1'b1;
          state       <= S_WR;
        end
        S_WR:  state <= S_IDLE;
        S_URD: state <= S_UWR;
        S_UWR: begin
          mem_wr_en   <= 1'b1;
          mem_wr_addr <= ram_rdata[EW-1:DATA_W];
          mem_wr_data <= ram_rdata[DATA_W-1:0];
          if (empty) begin
            tx_done <= 1'b1;
            state   <= S_IDLE;
          end else begin
            state <= S_URD;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R2: a grant follows the log gaining exactly one entry
  a_r2_gnt_logged: assert property (@(posedge clk) disable iff (rst)
    st_gnt |-> (count == $past(count) + CW'(1)));

  // R9: read and write strobes are exclusive
  a_r9_rd_wr_excl: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_en && mem_wr_en));

  // R6: completion leaves the log empty
  a_r6_done_empty: assert property (@(posedge clk) disable iff (rst)
    tx_done |-> empty);

  // R7: overflow flag only with a full log
  a_r7_ovf_full: assert property (@(posedge clk) disable iff (rst)
    log_ovf |-> full);

  // R8: no grant while a replay runs
  a_r8_no_gnt_replay: assert property (@(posedge clk) disable iff (rst)
    (state == S_URD || state == S_UWR) |-> !st_gnt);

endmodule

// File: tb/undo_log_ctrl_tb.sv
module undo_log_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int DEPTH = 8;
  localparam int NMEM = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic st_req = 1'b0;
  logic [AW-1:0] st_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic st_gnt, mem_rd_en, mem_wr_en, tx_done, log_ovf;
  logic [AW-1:0] mem_rd_addr, mem_wr_addr;
  logic [DW-1:0] mem_rd_data, mem_wr_data;
  logic tx_commit = 1'b0;
  logic tx_abort = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  undo_log_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LOG_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst),
    .st_req(st_req), .st_addr(st_addr), .st_data(st_data), .st_gnt(st_gnt),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .tx_commit(tx_commit), .tx_abort(tx_abort), .tx_done(tx_done), .log_ovf(log_ovf)
  );

  // memory behind the port, one-cycle read latency
  logic [DW-1:0] bmem [NMEM];
  int ref_mem [NMEM];
  initial begin
    for (int i = 0; i < NMEM; i++) begin
      bmem[i]    = DW'(i * 7 + 100);
      ref_mem[i] = (i * 7 + 100) & 16'hffff;
    end
  end
  always @(posedge clk) begin
    if (mem_rd_en) mem_rd_data <= bmem[mem_rd_addr];
    if (mem_wr_en) bmem[mem_wr_addr] <= mem_wr_data;
  end

  int n_vec = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: phase counter plus a queue of undo entries
  typedef struct { int a; int d; } ent_t;
  ent_t lq[$];
  int mph = 0;
  int cur_a = 0, cur_d = 0;
  bit e_rd = 0, e_wr = 0, e_gnt = 0, e_done = 0, e_ovf = 0;
  int e_rd_a = 0, e_wr_a = 0, e_wr_d = 0;

  always @(posedge clk) begin
    e_rd = 0; e_wr = 0; e_gnt = 0; e_done = 0;
    if (rst) begin
      mph = 0; e_ovf = 0; lq.delete();
    end else begin
      case (mph)
        0: begin
          if (tx_abort) begin
            e_ovf = 0;
            if (lq.size() == 0) e_done = 1; else mph = 10;
          end else if (tx_commit) begin
            e_ovf = 0; e_done = 1; lq.delete();
          end else if (st_req && !e_ovf) begin
            if (lq.size() == DEPTH) e_ovf = 1;
            else begin
              e_rd = 1; e_rd_a = int'(st_addr);
              cur_a = int'(st_addr); cur_d = int'(st_data); mph = 1;
            end
          end
        end
        1: mph = 2;
        2: begin
          lq.push_back('{a: cur_a, d: ref_mem[cur_a]});
          e_wr = 1; e_wr_a = cur_a; e_wr_d = cur_d; e_gnt = 1;
          ref_mem[cur_a] = cur_d;
          mph = 3;
        end
        3: mph = 0;
        10: mph = 11;
        11: begin
          ent_t en;
          en = lq.pop_back();
          e_wr = 1; e_wr_a = en.a; e_wr_d = en.d;
          ref_mem[en.a] = en.d;
          if (lq.size() == 0) begin e_done = 1; mph = 0; end
          else mph = 10;
        end
        default: mph = 0;
      endcase
    end
  end

  // cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk(mem_rd_en == e_rd, "R2 rd_en", int'(mem_rd_en), int'(e_rd));
      if (e_rd) chk(int'(mem_rd_addr) == e_rd_a, "R2 rd_addr", int'(mem_rd_addr), e_rd_a);
      chk(mem_wr_en == e_wr, (mph >= 10 || e_done) ? "R5 wr_en" : "R3 wr_en",
          int'(mem_wr_en), int'(e_wr));
      if (e_wr) begin
        chk(int'(mem_wr_addr) == e_wr_a, "R3/R5 wr_addr", int'(mem_wr_addr), e_wr_a);
        chk(int'(mem_wr_data) == e_wr_d, "R3/R5 wr_data", int'(mem_wr_data), e_wr_d);
      end
      chk(st_gnt == e_gnt, (mph >= 10) ? "R8 gnt" : "R2 gnt", int'(st_gnt), int'(e_gnt));
      chk(tx_done == e_done, "R6 done", int'(tx_done), int'(e_done));
      chk(log_ovf == e_ovf, "R7 ovf", int'(log_ovf), int'(e_ovf));
      chk(!(mem_rd_en && mem_wr_en), "R9 rd_wr_excl", int'(mem_wr_en), 0);
    end
  end

  task automatic do_store(input int a, input int d, output bit granted);
    @(negedge clk);
    st_req = 1'b1; st_addr = AW'(a); st_data = DW'(d);
    granted = 0;
    forever begin
      @(negedge clk);
      if (st_gnt) begin granted = 1; break; end
      if (log_ovf) break;
    end
    st_req = 1'b0;
  endtask

  task automatic pulse_abort();
    @(negedge clk); tx_abort = 1'b1;
    @(negedge clk); tx_abort = 1'b0;
  endtask

  task automatic pulse_commit();
    @(negedge clk); tx_commit = 1'b1;
    @(negedge clk); tx_commit = 1'b0;
  endtask

  task automatic wait_done();
    while (!tx_done) @(negedge clk);
  endtask

  function automatic bit mem_match();
    for (int i = 0; i < NMEM; i++)
      if (int'(bmem[i]) != ref_mem[i]) return 0;
    return 1;
  endfunction

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    bit g;
    bit seen_done;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!mem_rd_en && !mem_wr_en && !st_gnt && !tx_done && !log_ovf, "R1 reset outs",
        int'({mem_rd_en, mem_wr_en, st_gnt, tx_done, log_ovf}), 0);
    rst = 1'b0;
    chk(!mem_rd_en && !mem_wr_en && !st_gnt && !tx_done && !log_ovf, "R1 after reset",
        int'({mem_rd_en, mem_wr_en, st_gnt, tx_done, log_ovf}), 0);
    // empty abort at once: done next cycle (R6), no write (R1 empty log)
    pulse_abort();
    chk(tx_done && !mem_wr_en, "R6 empty abort done", int'(tx_done), 1);

    // R3 / R4: stores visible before commit, commit keeps them
    do_store(10, 16'h1111, g);
    chk(g, "R2 granted", int'(g), 1);
    @(negedge clk);
    chk(bmem[10] == 16'h1111, "R3 in place", int'(bmem[10]), 16'h1111);
    do_store(20, 16'h2222, g);
    do_store(10, 16'h3333, g);
    pulse_commit();
    chk(tx_done, "R4 commit done", int'(tx_done), 1);
    repeat (2) @(negedge clk);
    chk(bmem[10] == 16'h3333 && bmem[20] == 16'h2222, "R4 values kept",
        int'(bmem[10]), 16'h3333);
    chk(mem_match(), "R4 memory", 0, 1);

    // R5: repeated address restored to oldest value
    do_store(30, 16'hAAAA, g);
    do_store(31, 16'hBBBB, g);
    do_store(30, 16'hCCCC, g);
    do_store(30, 16'hDDDD, g);
    pulse_abort();
    wait_done();
    repeat (2) @(negedge clk);
    chk(int'(bmem[30]) == 30 * 7 + 100, "R5 oldest restored", int'(bmem[30]), 30 * 7 + 100);
    chk(int'(bmem[31]) == 31 * 7 + 100, "R5 restored", int'(bmem[31]), 31 * 7 + 100);
    chk(mem_match(), "R5 memory", 0, 1);

    // R7: fill the log then overflow
    for (int i = 0; i < DEPTH; i++) do_store(40 + i, 16'h5000 + i, g);
    do_store(60, 16'h6000, g);
    chk(!g && log_ovf, "R7 refused", int'(g), 0);
    do_store(61, 16'h6001, g);
    chk(!g, "R7 still refused", int'(g), 0);
    chk(int'(bmem[60]) == 60 * 7 + 100, "R7 no write", int'(bmem[60]), 60 * 7 + 100);
    pulse_abort();
    wait_done();
    @(negedge clk);
    chk(!log_ovf, "R7 cleared by abort", int'(log_ovf), 0);
    chk(mem_match(), "R5 full replay", 0, 1);

    // R8: request during replay waits for done
    do_store(70, 16'h7070, g);
    do_store(71, 16'h7171, g);
    pulse_abort();
    st_req = 1'b1; st_addr = AW'(72); st_data = 16'h7272;
    seen_done = 0; g = 0;
    while (!g) begin
      @(negedge clk);
      if (tx_done) seen_done = 1;
      if (st_gnt) g = 1;
    end
    st_req = 1'b0;
    chk(seen_done, "R8 grant after done", int'(seen_done), 1);
    pulse_commit();
    repeat (2) @(negedge clk);
    chk(bmem[72] == 16'h7272, "R8 served", int'(bmem[72]), 16'h7272);
    chk(mem_match(), "R8 memory", 0, 1);

    // R7: overflow cleared by commit
    for (int i = 0; i < DEPTH + 1; i++) do_store(80 + i, 16'h8000 + i, g);
    chk(log_ovf, "R7 set again", int'(log_ovf), 1);
    pulse_commit();
    @(negedge clk);
    chk(!log_ovf, "R7 cleared by commit", int'(log_ovf), 0);
    do_store(95, 16'h9595, g);
    chk(g, "R7 stores resume", int'(g), 1);
    repeat (4) @(negedge clk);

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule